// File: doc/BRIEF.md
# Isochronous transmit packing controller

This block sequences an isochronous transmitter that sends one bus packet per 125 µs bus cycle. When a cycle-start strobe arrives and the transmitter is running, it decides what the next packet will carry. It bases that choice on the FIFO occupancy (in quadlets), the data-block size and the latched packing parameters. The result is a header-only packet, an empty packet, or a packet with N whole data blocks. The block then requests arbitration. When the grant arrives it issues a one-cycle packet descriptor. After that it pulls the payload quadlets out of the FIFO through a read/ready handshake.

Software controls it through an enable level, a transmitter-reset level, a 2-bit packing mode and an 8-bit payload block limit. Clearing the enable is a soft stop: the packet in flight is completed and no new one is started. Raising the reset flushes the FIFO and abandons the transmission at once. The packing mode and the block limit are captured while the transmitter is stopped and held while it runs. The one exception is the block limit in MPEG-2 mode, which follows the live field.

Top module: `iso_tx_packer`

## Requirements
- R1: Packing mode 2'b11 yields a header-only descriptor (kind 2'b10) with zero blocks whatever the FIFO holds, and reads no quadlets.
- R2: Packing mode 2'b00 (variable) yields min(floor(level / block_size), block_limit) blocks with kind 2'b01. When that count is zero (including a block size of 0), the descriptor is empty (kind 2'b00) with zero blocks.
- R3: Packing mode 2'b01 (fixed) yields exactly block_limit blocks (kind 2'b01) when at least that many whole blocks are buffered. Otherwise it yields an empty descriptor (kind 2'b00, zero blocks).
- R4: Packing mode 2'b10 (MPEG-2) sizes packets as in R2, but a change to the block limit takes effect while the transmitter runs.
- R5: A cycle-start seen while the transmitter is running and idle raises the arbitration request on the next cycle. The cycle after the grant is sampled, the descriptor is valid for exactly one cycle and the request drops.
- R6: After a data descriptor, the FIFO read request stays high until blocks × block_size quadlets have been accepted. The busy flag is high from the arbitration request until the last quadlet, then low.
- R7: Clearing the enable during a packet lets that packet finish in full. No arbitration request follows a later cycle-start while the enable is low.
- R8: While the transmitter reset is high, the flush output is high in the same cycle. From the next cycle on, busy, arbitration request and FIFO read are low, and no packet starts.
- R9: Changes to the packing mode, and to the block limit outside MPEG-2 mode, made while the transmitter runs do not affect the packets it sends.
- R10: After the system reset, busy, arbitration request, descriptor valid and FIFO read are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cfg_enable | input | 1 | Transmitter enable level |
| cfg_reset | input | 1 | Transmitter reset level; flushes the FIFO |
| cfg_mode | input | 2 | Packing mode: 00 variable, 01 fixed, 10 MPEG-2, 11 header-only |
| cfg_max_blocks | input | 8 | Maximum data blocks per payload |
| cycle_start | input | 1 | One-cycle strobe at each bus cycle start |
| fifo_level | input | LVL_W (12) | Quadlets buffered in the FIFO |
| blk_size | input | DBS_W (8) | Data-block size in quadlets |
| arb_grant | input | 1 | Arbitration won for this cycle |
| fifo_rd_ok | input | 1 | FIFO accepts the read this cycle |
| arb_req | output | 1 | Request to arbitrate for the bus |
| pkt_valid | output | 1 | Packet descriptor valid (one cycle) |
| pkt_kind | output | 2 | 00 empty, 01 data, 10 header-only |
| pkt_blocks | output | 8 | Data blocks in the packet |
| fifo_rd | output | 1 | Read request for one payload quadlet |
| fifo_flush | output | 1 | Flush every byte held in the FIFO |
| busy | output | 1 | A packet is in flight |

## Verification
The arbitration request is due one clock after the cycle-start edge, and the descriptor one clock after the grant edge. The flush output follows the reset level in the same cycle, and the stopped state appears one clock later. The bench drives every input on the falling edge and samples one falling edge after the rising edge that should produce each result. Payload length is measured by counting the falling edges on which the read request is high while the FIFO accepts every read. The effect of disabling or resetting in mid-packet is observed from the outputs alone.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

    localparam int BLK_W = 8;

    typedef enum logic [1:0] {
        PM_VARIABLE = 2'b00,
        PM_FIXED    = 2'b01,
        PM_MPEG2    = 2'b10,
        PM_HDR_ONLY = 2'b11
    } pack_mode_e;

    typedef enum logic [1:0] {
        PK_EMPTY = 2'b00,
        PK_DATA  = 2'b01,
        PK_HDR   = 2'b10
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ARB  = 2'b01,
        ST_DATA = 2'b10
    } tx_state_e;

    typedef struct packed {
        pkt_kind_e          kind;
        logic [BLK_W-1:0]   blocks;
    } pkt_desc_t;

    function automatic logic [BLK_W-1:0] min_blk(input logic [BLK_W-1:0] a,
                                                 input logic [BLK_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/iso_tx_plan.sv
module iso_tx_plan
    import iso_tx_pkg::*;
#(
    parameter int LVL_W = 12,
    parameter int DBS_W = 8
) (
    input  pack_mode_e          mode,
    input  logic [BLK_W-1:0]    max_blk,
    input  logic [LVL_W-1:0]    level,
    input  logic [DBS_W-1:0]    dbs,
    output pkt_desc_t           desc
);
    localparam logic [LVL_W-1:0] SAT = LVL_W'((1 << BLK_W) - 1);

    logic [LVL_W-1:0] whole;
    logic [BLK_W-1:0] avail;
    logic [BLK_W-1:0] limited;

    always_comb begin
        whole   = (dbs == '0) ? '0 : level / LVL_W'(dbs);
        avail   = (whole > SAT) ? SAT[BLK_W-1:0] : whole[BLK_W-1:0];
        limited = min_blk(avail, max_blk);
        desc    = '{kind: PK_EMPTY, blocks: '0};
        unique case (mode)
            PM_HDR_ONLY: desc.kind = PK_HDR;
            PM_FIXED: begin
                if (max_blk != '0 && avail >= max_blk) begin
                    desc.kind   = PK_DATA;
                    desc.blocks = max_blk;
                end
            end
            default: begin
                if (limited != '0) begin
                    desc.kind   = PK_DATA;
                    desc.blocks = limited;
                end
            end
        endcase
    end
endmodule

// File: rtl/iso_tx_cfg_hold.sv
module iso_tx_cfg_hold
    import iso_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  pack_mode_e          cfg_mode,
    input  logic [BLK_W-1:0]    cfg_max,
    output pack_mode_e          mode_q,
    output logic [BLK_W-1:0]    max_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_VARIABLE;
            max_q  <= '0;
        end else if (!hold) begin
            mode_q <= cfg_mode;
            max_q  <= cfg_max;
        end else if (mode_q == PM_MPEG2) begin
            max_q  <= cfg_max;
        end
    end
endmodule

// File: rtl/iso_tx_packer.sv
module iso_tx_packer
    import iso_tx_pkg::*;
#(
    parameter int LVL_W = 12,
    parameter int DBS_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_enable,
    input  logic                cfg_reset,
    input  logic [1:0]          cfg_mode,
    input  logic [7:0]          cfg_max_blocks,
    input  logic                cycle_start,
    input  logic [LVL_W-1:0]    fifo_level,
    input  logic [DBS_W-1:0]    blk_size,
    input  logic                arb_grant,
    input  logic                fifo_rd_ok,
    output logic                arb_req,
    output logic                pkt_valid,
    output logic [1:0]          pkt_kind,
    output logic [7:0]          pkt_blocks,
    output logic                fifo_rd,
    output logic                fifo_flush,
    output logic                busy
);
    localparam int Q_W = BLK_W + DBS_W;

    tx_state_e          state;
    logic               run_q;
    logic               hold;
    logic               start;
    pack_mode_e         mode_q;
    logic [BLK_W-1:0]   max_q;
    pkt_desc_t          plan;
    pkt_desc_t          desc_q;
    logic [Q_W-1:0]     quads_q;
    logic [Q_W-1:0]     left_q;

    assign hold  = (state != ST_IDLE) || run_q;
    assign start = (state == ST_IDLE) && run_q && cfg_enable && !cfg_reset && cycle_start;

    iso_tx_cfg_hold i_cfg (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .cfg_mode (pack_mode_e'(cfg_mode)),
        .cfg_max  (cfg_max_blocks),
        .mode_q   (mode_q),
        .max_q    (max_q)
    );

    iso_tx_plan #(.LVL_W(LVL_W), .DBS_W(DBS_W)) i_plan (
        .mode    (mode_q),
        .max_blk (max_q),
        .level   (fifo_level),
        .dbs     (blk_size),
        .desc    (plan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            run_q      <= 1'b0;
            desc_q     <= '{kind: PK_EMPTY, blocks: '0};
            quads_q    <= '0;
            left_q     <= '0;
            pkt_valid  <= 1'b0;
            pkt_kind   <= PK_EMPTY;
            pkt_blocks <= '0;
        end else begin
            run_q     <= cfg_enable && !cfg_reset;
            pkt_valid <= 1'b0;
            if (cfg_reset) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (start) begin
                            desc_q  <= plan;
                            quads_q <= Q_W'(plan.blocks) * Q_W'(blk_size);
                            state   <= ST_ARB;
                        end
                    end
                    ST_ARB: begin
                        if (arb_grant) begin
                            pkt_valid  <= 1'b1;
                            pkt_kind   <= desc_q.kind;
                            pkt_blocks <= desc_q.blocks;
                            left_q     <= quads_q;
                            state      <= (desc_q.kind == PK_DATA && quads_q != '0)
                                          ? ST_DATA : ST_IDLE;
                        end
                    end
                    ST_DATA: begin
                        if (fifo_rd_ok) begin
                            left_q <= left_q - 1'b1;
                            if (left_q == Q_W'(1)) state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign arb_req    = (state == ST_ARB);
    assign fifo_rd    = (state == ST_DATA);
    assign busy       = (state != ST_IDLE);
    assign fifo_flush = cfg_reset;

endmodule

// File: rtl/iso_tx_packer_chk.sv
module iso_tx_packer_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_enable,
    input logic       cfg_reset,
    input logic       arb_grant,
    input logic       arb_req,
    input logic       pkt_valid,
    input logic [1:0] pkt_kind,
    input logic [7:0] pkt_blocks,
    input logic       fifo_rd,
    input logic       busy
);
    AST_RESET_STOPS: assert property (@(posedge clk) disable iff (rst)
        cfg_reset |=> (!busy && !pkt_valid && !fifo_rd)); // R8

    AST_NODATA_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_kind != 2'b01) |-> (pkt_blocks == 8'd0)); // R1

    AST_PKT_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> $past(arb_req && arb_grant)); // R5

    AST_SINGLE_DESC: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> !pkt_valid); // R5

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_enable) |=> !busy); // R7

    AST_READ_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_rd) |-> (pkt_valid && pkt_kind == 2'b01 && pkt_blocks != 8'd0)); // R6
endmodule

bind iso_tx_packer iso_tx_packer_chk i_chk (.*);

// File: tb/test_iso_tx_packer.sv
`timescale 1ns/1ps
module test_iso_tx_packer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic        cfg_reset = 1'b1;
    logic [1:0]  cfg_mode = 2'b00;
    logic [7:0]  cfg_max_blocks = 8'd0;
    logic        cycle_start = 1'b0;
    logic [11:0] fifo_level = '0;
    logic [7:0]  blk_size = 8'd4;
    logic        arb_grant = 1'b0;
    logic        fifo_rd_ok = 1'b0;
    logic        arb_req, pkt_valid, fifo_rd, fifo_flush, busy;
    logic [1:0]  pkt_kind;
    logic [7:0]  pkt_blocks;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    iso_tx_packer i_iso_tx_packer (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic rs, input logic [1:0] md,
                           input logic [7:0] mx);
        cfg_enable = en; cfg_reset = rs; cfg_mode = md; cfg_max_blocks = mx;
        @(negedge clk);
    endtask

    // cycle start, grant, drain; drop enable after drop_at quadlets (-1: never)
    task automatic run_pkt(input logic [11:0] lvl, input int drop_at,
                           output int kind, output int blks, output int quads,
                           output bit started);
        kind = -1; blks = -1; quads = 0;
        fifo_level = lvl; cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        started = arb_req;
        if (!started) return;
        chk("R6 busy with request", busy, 1);
        arb_grant = 1'b1;
        @(negedge clk);
        arb_grant = 1'b0;
        chk("R5 descriptor valid after grant", pkt_valid, 1);
        chk("R5 request dropped", arb_req, 0);
        kind = pkt_kind; blks = pkt_blocks;
        fifo_rd_ok = 1'b1;
        while (fifo_rd && quads < 70000) begin
            if (quads == drop_at) cfg_enable = 1'b0;
            quads++;
            @(negedge clk);
        end
        fifo_rd_ok = 1'b0;
        chk("R6 busy low after payload", busy, 0);
    endtask

    task automatic t_reset;
        chk("R10 busy", busy, 0);
        chk("R10 arb_req", arb_req, 0);
        chk("R10 pkt_valid", pkt_valid, 0);
        chk("R10 fifo_rd", fifo_rd, 0);
        chk("R8 flush follows reset level", fifo_flush, 1);
    endtask

    task automatic t_variable;
        int k, b, q; bit s;
        set_cfg(0, 0, 2'b00, 8'd8);
        set_cfg(1, 0, 2'b00, 8'd8);
        blk_size = 8'd4;
        run_pkt(12'd10, -1, k, b, q, s);
        chk("R5 started", s, 1); chk("R2 kind", k, 1); chk("R2 blocks", b, 2); chk("R6 quads", q, 8);
        run_pkt(12'd100, -1, k, b, q, s);
        chk("R2 limit kind", k, 1); chk("R2 limit blocks", b, 8); chk("R6 limit quads", q, 32);
        run_pkt(12'd3, -1, k, b, q, s);
        chk("R2 empty kind", k, 0); chk("R2 empty blocks", b, 0); chk("R2 empty quads", q, 0);
        blk_size = 8'd0;
        run_pkt(12'd50, -1, k, b, q, s);
        chk("R2 zero size kind", k, 0); chk("R2 zero size quads", q, 0);
        blk_size = 8'd4;
    endtask

    task automatic t_fixed;
        int k, b, q; bit s;
        set_cfg(0, 0, 2'b01, 8'd4);
        set_cfg(1, 0, 2'b01, 8'd4);
        run_pkt(12'd16, -1, k, b, q, s);
        chk("R3 full kind", k, 1); chk("R3 full blocks", b, 4); chk("R3 full quads", q, 16);
        run_pkt(12'd15, -1, k, b, q, s);
        chk("R3 short kind", k, 0); chk("R3 short blocks", b, 0); chk("R3 short quads", q, 0);
    endtask

    task automatic t_hdr_only;
        int k, b, q; bit s;
        set_cfg(0, 0, 2'b11, 8'd8);
        set_cfg(1, 0, 2'b11, 8'd8);
        run_pkt(12'd100, -1, k, b, q, s);
        chk("R1 kind", k, 2); chk("R1 blocks", b, 0); chk("R1 quads", q, 0);
    endtask

    task automatic t_latched;
        int k, b, q; bit s;
        set_cfg(0, 0, 2'b00, 8'd8);
        set_cfg(1, 0, 2'b00, 8'd8);
        set_cfg(1, 0, 2'b11, 8'd2);
        run_pkt(12'd100, -1, k, b, q, s);
        chk("R9 mode held kind", k, 1); chk("R9 limit held blocks", b, 8);
    endtask

    task automatic t_mpeg;
        int k, b, q; bit s;
        set_cfg(0, 0, 2'b10, 8'd8);
        set_cfg(1, 0, 2'b10, 8'd8);
        run_pkt(12'd100, -1, k, b, q, s);
        chk("R4 blocks", b, 8);
        set_cfg(1, 0, 2'b10, 8'd3);
        run_pkt(12'd100, -1, k, b, q, s);
        chk("R4 live limit kind", k, 1); chk("R4 live limit blocks", b, 3); chk("R4 quads", q, 12);
    endtask

    task automatic t_graceful;
        int k, b, q; bit s;
        set_cfg(0, 0, 2'b00, 8'd8);
        set_cfg(1, 0, 2'b00, 8'd8);
        run_pkt(12'd100, 5, k, b, q, s);
        chk("R7 packet finished", q, 32);
        run_pkt(12'd100, -1, k, b, q, s);
        chk("R7 no new request", s, 0);
        chk("R7 idle", busy, 0);
    endtask

    task automatic t_hard_reset;
        set_cfg(1, 0, 2'b00, 8'd8);
        fifo_level = 12'd100; cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0; arb_grant = 1'b1;
        @(negedge clk);
        arb_grant = 1'b0; fifo_rd_ok = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 reading before reset", fifo_rd, 1);
        cfg_reset = 1'b1;
        #1;
        chk("R8 flush same cycle", fifo_flush, 1);
        @(negedge clk);
        fifo_rd_ok = 1'b0;
        chk("R8 busy low", busy, 0);
        chk("R8 read low", fifo_rd, 0);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        chk("R8 no request in reset", arb_req, 0);
        cfg_reset = 1'b0;
        @(negedge clk);
        chk("R8 flush released", fifo_flush, 0);
    endtask

    initial begin
        #(100000 * 5);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_variable();
        t_fixed();
        t_hdr_only();
        t_latched();
        t_mpeg();
        t_graceful();
        t_hard_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule